// File: doc/BRIEF.md
# Prioritized Multi-Lane Command Staging Bank

This block stages 32-bit command words on their way from command lists held in memory to a conversion engine. It holds six independent lanes, one for each command list. Each lane is a four-entry first-in first-out store with its own write port. While a lane can take more words and its list is still running, it raises a refill request, so a fetch engine upstream knows where to write next.

A single output port with a valid/ready handshake serves all lanes. It always presents the head word of the lowest-numbered lane that holds data, and it reports that lane's index. Lane 0 has the highest priority. The most significant bit of each command word, bit 0 in MSB-first numbering, marks the last command of a list. When such a word leaves through the output, the lane's controller moves from its running state to its drained state. The lane then raises a sticky end-of-list flag and stops requesting refills until software clears the flag. A write to a full lane is dropped and sets a sticky overflow flag.

Each lane controller has two states. LANE_RUN is entered on reset; its transition run-to-done happens when a word with the end-of-list bit is popped from the lane. LANE_DONE holds the end-of-list flag; its transition done-to-run happens on a clear pulse in a cycle that does not also pop another end-of-list word from the lane.

Top module: `cmdq_bank`

## Requirements
- R1: After a synchronous reset, every lane is empty with occupancy 0, all end-of-list and overflow flags are 0, `out_valid` is 0 and every `fill_req` bit is 1.
- R2: Each lane returns its words in write order and holds up to 4 of them. `lane_count` (3 bits per lane, lane i at bits [3i+2:3i]) goes from 0 to 4. `lane_full` is 1 exactly at count 4 and `lane_empty` is 1 exactly at count 0.
- R3: `fill_req[i]` is 1 exactly when lane i is not full and its end-of-list flag is 0.
- R4: When any lane holds data, `out_data` is the oldest word of the lowest-numbered non-empty lane and `out_src` is that lane's index.
- R5: `out_valid` is 1 exactly when at least one lane holds data. A word is removed only in a cycle with `out_valid` and `out_ready` both 1. While `out_ready` is 0 no lane loses a word.
- R6: Popping a word whose bit 31 is 1 sets that lane's end-of-list flag on the next cycle. The flag stays set until a clear. If a clear and such a pop happen in the same cycle, the flag remains set.
- R7: A one-cycle pulse on `eoq_clr[i]` clears lane i's end-of-list flag, and `fill_req[i]` returns if the lane is not full.
- R8: A write to a lane that is full at the start of the cycle is dropped, even if the same cycle pops that lane. The lane's overflow flag becomes 1 and stays 1 until reset.
- R9: A lane with its end-of-list flag set still accepts writes while it is not full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| push_valid | input | 6 | Per-lane write strobe |
| push_data | input | 192 | Per-lane write word, lane i at bits [32i+31:32i] |
| eoq_clr | input | 6 | Per-lane clear pulse for the end-of-list flag |
| out_ready | input | 1 | Downstream accepts the presented word |
| fill_req | output | 6 | Per-lane refill request |
| lane_full | output | 6 | Per-lane full status |
| lane_empty | output | 6 | Per-lane empty status |
| lane_count | output | 18 | Per-lane occupancy, 3 bits each |
| eoq_flag | output | 6 | Per-lane sticky end-of-list flag |
| ovf_flag | output | 6 | Per-lane sticky overflow flag |
| out_valid | output | 1 | A word is presented |
| out_data | output | 32 | Presented command word |
| out_src | output | 3 | Index of the lane the word comes from |

## Verification
Single-lane bursts, with the output stalled and then released, show write order and exact capacity. A fifth write into a stalled lane separates a dropped write from an accepted one. Filling all lanes at once and then draining shows whether selection is by lane number or by arrival. Lists ending with the end-of-list bit, with clears placed before, on and after the pop, separate set-wins behaviour from clear-wins behaviour and from refill gating. A long mixed run with random writes, stalls and clears is compared every cycle with a behavioural queue model. It exposes counting and pointer errors that appear only when writes and pops overlap.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
    typedef enum logic [0:0] {
        LANE_RUN  = 1'b0,
        LANE_DONE = 1'b1
    } lane_state_e;
endpackage

// File: rtl/cmdq_fifo.sv
module cmdq_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty,
    output logic             push_drop
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic             push_ok, pop_ok;

    assign full      = (count == CNT_W'(DEPTH));
    assign empty     = (count == '0);
    assign push_ok   = push && !full;
    assign push_drop = push && full;
    assign pop_ok    = pop && !empty;
    assign head      = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= nxt(wr_ptr);
            if (pop_ok)  rd_ptr <= nxt(rd_ptr);
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end
endmodule

// File: rtl/cmdq_lane_ctl.sv
module cmdq_lane_ctl
    import cmdq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic eoq_pop,
    input  logic clr,
    input  logic push_drop,
    input  logic full,
    output logic eoq_flag,
    output logic ovf_flag,
    output logic fill_req
);
    lane_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (rst) state <= LANE_RUN;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            LANE_RUN:  if (eoq_pop)          state_nx = LANE_DONE;
            LANE_DONE: if (clr && !eoq_pop)  state_nx = LANE_RUN;
            default:                         state_nx = LANE_RUN;
        endcase
    end

    always_comb begin
        eoq_flag = (state == LANE_DONE);
        fill_req = !full && (state == LANE_RUN);
    end

    always_ff @(posedge clk) begin
        if (rst)            ovf_flag <= 1'b0;
        else if (push_drop) ovf_flag <= 1'b1;
    end
endmodule

// File: rtl/cmdq_arbiter.sv
module cmdq_arbiter #(
    parameter int NQ = 6,
    localparam int IDX_W = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic [NQ-1:0]    empty,
    input  logic             ready,
    output logic             valid,
    output logic [IDX_W-1:0] idx,
    output logic [NQ-1:0]    pop_vec
);
    always_comb begin
        idx = '0;
        for (int i = NQ - 1; i >= 0; i--) begin
            if (!empty[i]) idx = IDX_W'(i);
        end
        valid = !(&empty);
    end

    for (genvar g = 0; g < NQ; g++) begin : g_pop
        assign pop_vec[g] = valid && ready && (idx == IDX_W'(g));
    end
endmodule

// File: rtl/cmdq_bank.sv
module cmdq_bank #(
    parameter int NQ    = 6,
    parameter int DEPTH = 4,
    parameter int W     = 32,
    localparam int IDX_W = (NQ > 1) ? $clog2(NQ) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NQ-1:0]       push_valid,
    input  logic [NQ*W-1:0]     push_data,
    input  logic [NQ-1:0]       eoq_clr,
    input  logic                out_ready,
    output logic [NQ-1:0]       fill_req,
    output logic [NQ-1:0]       lane_full,
    output logic [NQ-1:0]       lane_empty,
    output logic [NQ*CNT_W-1:0] lane_count,
    output logic [NQ-1:0]       eoq_flag,
    output logic [NQ-1:0]       ovf_flag,
    output logic                out_valid,
    output logic [W-1:0]        out_data,
    output logic [IDX_W-1:0]    out_src
);
    localparam int EOQ_POS = W - 1;

    logic [W-1:0]  heads [NQ];
    logic [NQ-1:0] pop_vec;
    logic [NQ-1:0] drop_vec;
    logic [NQ-1:0] eoq_pop;

    cmdq_arbiter #(.NQ(NQ)) u_arb (
        .empty   (lane_empty),
        .ready   (out_ready),
        .valid   (out_valid),
        .idx     (out_src),
        .pop_vec (pop_vec)
    );

    for (genvar g = 0; g < NQ; g++) begin : g_lane
        cmdq_fifo #(.DEPTH(DEPTH), .W(W)) u_fifo (
            .clk       (clk),
            .rst       (rst),
            .push      (push_valid[g]),
            .push_data (push_data[g*W +: W]),
            .pop       (pop_vec[g]),
            .head      (heads[g]),
            .count     (lane_count[g*CNT_W +: CNT_W]),
            .full      (lane_full[g]),
            .empty     (lane_empty[g]),
            .push_drop (drop_vec[g])
        );

        assign eoq_pop[g] = pop_vec[g] && heads[g][EOQ_POS];

        cmdq_lane_ctl u_ctl (
            .clk       (clk),
            .rst       (rst),
            .eoq_pop   (eoq_pop[g]),
            .clr       (eoq_clr[g]),
            .push_drop (drop_vec[g]),
            .full      (lane_full[g]),
            .eoq_flag  (eoq_flag[g]),
            .ovf_flag  (ovf_flag[g]),
            .fill_req  (fill_req[g])
        );
    end

    always_comb begin
        out_data = '0;
        for (int i = 0; i < NQ; i++) begin
            if (out_src == IDX_W'(i)) out_data = heads[i];
        end
    end
endmodule

// File: rtl/cmdq_bank_chk.sv
module cmdq_bank_chk #(
    parameter int NQ    = 6,
    parameter int DEPTH = 4,
    parameter int W     = 32,
    localparam int IDX_W = (NQ > 1) ? $clog2(NQ) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic                clk,
    input logic                rst,
    input logic [NQ-1:0]       push_valid,
    input logic [NQ-1:0]       eoq_clr,
    input logic                out_ready,
    input logic [NQ-1:0]       fill_req,
    input logic [NQ-1:0]       lane_full,
    input logic [NQ-1:0]       lane_empty,
    input logic [NQ*CNT_W-1:0] lane_count,
    input logic [NQ-1:0]       eoq_flag,
    input logic [NQ-1:0]       ovf_flag,
    input logic                out_valid,
    input logic [IDX_W-1:0]    out_src
);
    logic [NQ-1:0] lower_mask;
    assign lower_mask = (NQ'(1) << out_src) - NQ'(1);

    // R4: nothing with a lower index may hold data while another lane is served
    a_r4_priority: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (((~lane_empty) & lower_mask) == '0 && !lane_empty[out_src]));

    // R5: with all lanes empty nothing is presented
    a_r5_no_valid_when_empty: assert property (@(posedge clk) disable iff (rst)
        (&lane_empty) |-> !out_valid);

    for (genvar g = 0; g < NQ; g++) begin : g_chk
        // R2: occupancy bound
        a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
            lane_count[g*CNT_W +: CNT_W] <= CNT_W'(DEPTH));

        // R5: stalled output keeps every word
        a_r5_no_loss_stalled: assert property (@(posedge clk) disable iff (rst)
            (!out_ready && !push_valid[g]) |=> $stable(lane_count[g*CNT_W +: CNT_W]));

        // R6: end-of-list flag sticky without clear
        a_r6_eoq_sticky: assert property (@(posedge clk) disable iff (rst)
            (eoq_flag[g] && !eoq_clr[g]) |=> eoq_flag[g]);

        // R8: write into full lane raises overflow
        a_r8_overflow_set: assert property (@(posedge clk) disable iff (rst)
            (push_valid[g] && lane_full[g]) |=> ovf_flag[g]);

        // R8: overflow flag never falls outside reset
        a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
            ovf_flag[g] |=> ovf_flag[g]);

        // R3: refill request withheld while drained or full
        a_r3_fill_gate: assert property (@(posedge clk) disable iff (rst)
            (eoq_flag[g] || lane_full[g]) |-> !fill_req[g]);
    end
endmodule

bind cmdq_bank cmdq_bank_chk #(.NQ(NQ), .DEPTH(DEPTH), .W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .push_valid (push_valid),
    .eoq_clr    (eoq_clr),
    .out_ready  (out_ready),
    .fill_req   (fill_req),
    .lane_full  (lane_full),
    .lane_empty (lane_empty),
    .lane_count (lane_count),
    .eoq_flag   (eoq_flag),
    .ovf_flag   (ovf_flag),
    .out_valid  (out_valid),
    .out_src    (out_src)
);

// File: tb/sim_cmdq_bank.sv
`timescale 1ns/1ps
module sim_cmdq_bank;
    localparam int NQ = 6;
    localparam int DEPTH = 4;
    localparam int W = 32;

    logic              clk = 1'b0;
    logic              rst;
    logic [NQ-1:0]     push_valid;
    logic [NQ*W-1:0]   push_data;
    logic [NQ-1:0]     eoq_clr;
    logic              out_ready;
    logic [NQ-1:0]     fill_req, lane_full, lane_empty, eoq_flag, ovf_flag;
    logic [NQ*3-1:0]   lane_count;
    logic              out_valid;
    logic [W-1:0]      out_data;
    logic [2:0]        out_src;

    int checks = 0;
    int errors = 0;

    logic [31:0] mq [NQ][$];
    bit          meoq [NQ];
    bit          movf [NQ];
    int          seq = 0;

    always #4 clk = ~clk;

    cmdq_bank u0 (
        .clk(clk), .rst(rst), .push_valid(push_valid), .push_data(push_data),
        .eoq_clr(eoq_clr), .out_ready(out_ready), .fill_req(fill_req),
        .lane_full(lane_full), .lane_empty(lane_empty), .lane_count(lane_count),
        .eoq_flag(eoq_flag), .ovf_flag(ovf_flag), .out_valid(out_valid),
        .out_data(out_data), .out_src(out_src)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int first_busy();
        for (int i = 0; i < NQ; i++) if (mq[i].size() != 0) return i;
        return -1;
    endfunction

    task automatic compare();
        int s;
        s = first_busy();
        chk("R5 out_valid", 64'(out_valid), 64'(s >= 0));
        if (s >= 0) begin
            chk("R4 out_src", 64'(out_src), 64'(s));
            chk("R4 R2 out_data", 64'(out_data), 64'(mq[s][0]));
        end
        for (int i = 0; i < NQ; i++) begin
            chk("R2 lane_count", 64'(lane_count[i*3 +: 3]), 64'(mq[i].size()));
            chk("R2 lane_full", 64'(lane_full[i]), 64'(mq[i].size() == DEPTH));
            chk("R2 lane_empty", 64'(lane_empty[i]), 64'(mq[i].size() == 0));
            chk("R3 fill_req", 64'(fill_req[i]), 64'(mq[i].size() != DEPTH && !meoq[i]));
            chk("R6 R7 eoq_flag", 64'(eoq_flag[i]), 64'(meoq[i]));
            chk("R8 ovf_flag", 64'(ovf_flag[i]), 64'(movf[i]));
        end
    endtask

    task automatic model_update();
        int s;
        bit was_full [NQ];
        bit set_eoq [NQ];
        for (int i = 0; i < NQ; i++) begin
            was_full[i] = (mq[i].size() == DEPTH);
            set_eoq[i] = 1'b0;
        end
        s = first_busy();
        if (s >= 0 && out_ready) begin
            logic [31:0] w;
            w = mq[s].pop_front();
            if (w[31]) set_eoq[s] = 1'b1;
        end
        for (int i = 0; i < NQ; i++) begin
            if (set_eoq[i]) meoq[i] = 1'b1;
            else if (eoq_clr[i]) meoq[i] = 1'b0;
            if (push_valid[i]) begin
                if (was_full[i]) movf[i] = 1'b1;
                else mq[i].push_back(push_data[i*W +: W]);
            end
        end
    endtask

    // one clock: inputs are already driven just after a falling edge
    task automatic cycle();
        #1;
        compare();
        model_update();
        @(negedge clk);
        push_valid = '0;
        eoq_clr = '0;
    endtask

    task automatic put(input int lane, input bit last);
        seq++;
        push_valid[lane] = 1'b1;
        push_data[lane*W +: W] = {last, 3'(lane), 28'(seq)};
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cycle();
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        push_valid = '0;
        push_data = '0;
        eoq_clr = '0;
        out_ready = 1'b0;
        for (int i = 0; i < NQ; i++) begin meoq[i] = 0; movf[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        #1;
        chk("R1 out_valid", 64'(out_valid), 64'd0);
        chk("R1 fill_req", 64'(fill_req), 64'h3f);
        chk("R1 lane_empty", 64'(lane_empty), 64'h3f);
        chk("R1 lane_count", 64'(lane_count), 64'd0);
        chk("R1 flags", 64'({eoq_flag, ovf_flag}), 64'd0);
        @(negedge clk);

        // R2 R8: stalled lane 2 takes four words, fifth is dropped
        for (int k = 0; k < 5; k++) begin put(2, 0); cycle(); end
        chk("R8 ovf lane2", 64'(ovf_flag[2]), 64'd1);
        chk("R2 count lane2", 64'(lane_count[6 +: 3]), 64'd4);
        // R8: write to full lane while it is popped is still dropped
        out_ready = 1'b1;
        put(2, 0);
        cycle();
        chk("R8 count after pop+drop", 64'(lane_count[6 +: 3]), 64'd3);
        idle(4);

        // R4: all lanes filled while stalled, drain in lane order
        out_ready = 1'b0;
        for (int k = 0; k < 3; k++) begin
            for (int i = NQ - 1; i >= 0; i--) put(i, 0);
            cycle();
        end
        out_ready = 1'b1;
        idle(20);

        // R6 R3 R9 R7: list on lane 1 ending with the marker
        out_ready = 1'b0;
        put(1, 0); cycle();
        put(1, 1); cycle();
        out_ready = 1'b1;
        idle(3);
        chk("R6 eoq lane1 set", 64'(eoq_flag[1]), 64'd1);
        chk("R3 fill_req lane1 gated", 64'(fill_req[1]), 64'd0);
        out_ready = 1'b0;
        put(1, 0); cycle();   // R9: accepted while drained
        chk("R9 count lane1", 64'(lane_count[3 +: 3]), 64'd1);
        eoq_clr[1] = 1'b1; cycle();
        chk("R7 eoq lane1 cleared", 64'(eoq_flag[1]), 64'd0);
        chk("R7 fill_req lane1 back", 64'(fill_req[1]), 64'd1);
        // R6: clear on the same cycle as a marker pop, set wins
        put(1, 1); cycle();
        out_ready = 1'b1;
        cycle();              // pops the plain word
        eoq_clr[1] = 1'b1;    // marker word popped this cycle
        cycle();
        chk("R6 set wins over clear", 64'(eoq_flag[1]), 64'd1);
        eoq_clr[1] = 1'b1; cycle();
        idle(2);

        // mixed random traffic
        for (int k = 0; k < 4000; k++) begin
            for (int i = 0; i < NQ; i++) begin
                if ($urandom_range(0, 99) < 45) put(i, $urandom_range(0, 7) == 0);
                if ($urandom_range(0, 15) == 0) eoq_clr[i] = 1'b1;
            end
            out_ready = ($urandom_range(0, 9) < 7);
            cycle();
        end
        out_ready = 1'b1;
        idle(30);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule